// File: doc/BRIEF.md
# Receive Acceptance Filter with Message Object Store

This block keeps a small array of message objects and decides which one, if any, takes a received bus frame. Each object holds a valid bit, a direction bit, an identifier and a per-bit identifier mask, plus the last stored DLC and data bytes. When the receiver has decoded an identifier, it raises `id_valid_i`. The filter then walks the objects one per clock, starting at object 0. It stops at the first active receive object whose identifier agrees with the received one on every bit the mask enables.

When the frame has ended, the receiver pulses `frame_done_i` with the DLC and the data bytes. The block then writes the whole frame into the chosen object: identifier, DLC and all data bytes. Identifier bits that the mask ignores therefore take the received values. If no object qualifies, the frame is dropped. The CPU can rewrite an object's configuration at any time. A rewrite of an object at or below the current scan position while a frame is pending makes the filter resume scanning from that object. The frame cannot then land in an object chosen under stale settings.

Top module: `afl_top`

## Requirements
- R1: An object whose valid bit is 0 never matches, whatever its identifier and mask.
- R2: An active receive object matches when `((rx_id ^ obj_id) & obj_mask) == 0`. A mask bit of 1 makes that identifier bit take part in the compare; a mask bit of 0 makes it a don't-care.
- R3: An object whose transmit-direction bit (`cfg_tx_i`) is 1 never matches a received frame.
- R4: When several objects match, the one with the lowest index is chosen and reported on `match_idx_o`.
- R5: The write into an object happens only after `frame_done_i` has been seen for the pending frame. `store_o` is a one-cycle pulse that follows a cycle with `hit_o` high, and `match_idx_o` names the written object while `store_o` is high.
- R6: A stored frame replaces the object's identifier, DLC and all data bytes, which then read back through `rd_idx_i`.
- R7: Identifier bits whose mask bit is 0 are replaced by the received bits on store; the mask, valid and direction settings are left unchanged.
- R8: If no object matches, `hit_o` stays low, no `store_o` pulse occurs, and every object reads back unchanged.
- R9: While a frame is pending, a configuration write to object k with k at or below the current scan position (the found index, or past the last object after a miss) restarts the scan at k, using the new settings of k.
- R10: A configuration write to an object above the found index leaves the found index and the stored destination unchanged.
- R11: After reset, `hit_o` and `store_o` are low and every object reads back identifier 0, DLC 0 and data 0, with valid cleared.
- R12: The scan tests one object per clock. For a first match at index K, `hit_o` rises K+1 clock edges after the edge that samples `id_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| id_valid_i | input | 1 | Received identifier available; starts a new filter pass |
| rx_id_i | input | ID_W | Received identifier, sampled with `id_valid_i` |
| frame_done_i | input | 1 | Frame complete; DLC and data are valid |
| rx_dlc_i | input | 4 | Received DLC, sampled with `frame_done_i` |
| rx_data_i | input | 8*MAX_BYTES | Received data bytes, byte 0 in the low bits |
| cfg_we_i | input | 1 | CPU object update strobe |
| cfg_idx_i | input | $clog2(NUM_OBJ) | Index of the updated object |
| cfg_valid_i | input | 1 | New valid bit |
| cfg_tx_i | input | 1 | New direction bit, 1 = transmit |
| cfg_id_i | input | ID_W | New identifier |
| cfg_mask_i | input | ID_W | New identifier mask |
| rd_idx_i | input | $clog2(NUM_OBJ) | Readback object select |
| rd_id_o | output | ID_W | Identifier of the selected object |
| rd_dlc_o | output | 4 | Stored DLC of the selected object |
| rd_data_o | output | 8*MAX_BYTES | Stored data of the selected object |
| hit_o | output | 1 | A matching object is held for the pending frame |
| match_idx_o | output | $clog2(NUM_OBJ) | Found or stored object index |
| store_o | output | 1 | One-cycle pulse: frame written into `match_idx_o` |

## Verification
The assertions assume that `id_valid_i` and `frame_done_i` are single-cycle pulses, that `frame_done_i` follows its own `id_valid_i` and comes before the next one, and that `cfg_idx_i` is below the object count whenever `cfg_we_i` is high. The bench drives each strobe for exactly one clock from the falling edge. It opens every frame with `id_valid_i` and closes it with `frame_done_i` before the next frame begins. It sweeps only legal object indices.

// File: rtl/afl_pkg.sv
package afl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_FOUND = 2'd2,
    ST_MISS  = 2'd3
  } afl_state_e;
endpackage

// File: rtl/afl_match.sv
module afl_match #(
  parameter int ID_W = 29
) (
  input  logic            valid_i,
  input  logic            tx_i,
  input  logic [ID_W-1:0] obj_id_i,
  input  logic [ID_W-1:0] mask_i,
  input  logic [ID_W-1:0] rx_id_i,
  output logic            match_o
);
  logic [ID_W-1:0] diff;

  assign diff    = (rx_id_i ^ obj_id_i) & mask_i;
  assign match_o = valid_i & ~tx_i & (diff == '0);
endmodule

// File: rtl/afl_obj_store.sv
module afl_obj_store #(
  parameter int NUM_OBJ = 32,
  parameter int ID_W    = 29,
  parameter int DLC_W   = 4,
  parameter int DATA_W  = 64,
  parameter int IDX_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_tx_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic [ID_W-1:0]   cfg_mask_i,
  input  logic              st_we_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  logic [ID_W-1:0]   st_id_i,
  input  logic [DLC_W-1:0]  st_dlc_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [IDX_W-1:0]  sel_idx_i,
  output logic              sel_valid_o,
  output logic              sel_tx_o,
  output logic [ID_W-1:0]   sel_id_o,
  output logic [ID_W-1:0]   sel_mask_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [DLC_W-1:0]  rd_dlc_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [NUM_OBJ-1:0] valid_q;
  logic [NUM_OBJ-1:0] tx_q;
  logic [ID_W-1:0]    id_q   [NUM_OBJ];
  logic [ID_W-1:0]    mask_q [NUM_OBJ];
  logic [DLC_W-1:0]   dlc_q  [NUM_OBJ];
  logic [DATA_W-1:0]  data_q [NUM_OBJ];

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    logic cfg_hit, st_hit;
    assign cfg_hit = cfg_we_i && (cfg_idx_i == IDX_W'(g));
    assign st_hit  = st_we_i  && (st_idx_i  == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tx_q[g]    <= 1'b0;
        id_q[g]    <= '0;
        mask_q[g]  <= '0;
        dlc_q[g]   <= '0;
        data_q[g]  <= '0;
      end else begin
        if (st_hit) begin
          id_q[g]   <= st_id_i;
          dlc_q[g]  <= st_dlc_i;
          data_q[g] <= st_data_i;
        end
        // configuration wins over a colliding store
        if (cfg_hit) begin
          valid_q[g] <= cfg_valid_i;
          tx_q[g]    <= cfg_tx_i;
          id_q[g]    <= cfg_id_i;
          mask_q[g]  <= cfg_mask_i;
        end
      end
    end
  end

  assign sel_valid_o = valid_q[sel_idx_i];
  assign sel_tx_o    = tx_q[sel_idx_i];
  assign sel_id_o    = id_q[sel_idx_i];
  assign sel_mask_o  = mask_q[sel_idx_i];

  assign rd_id_o   = id_q[rd_idx_i];
  assign rd_dlc_o  = dlc_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];

  // R6
  stored_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !(cfg_we_i && cfg_idx_i == st_idx_i))
    |=> (id_q[$past(st_idx_i)] == $past(st_id_i)));

  // R7
  stored_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_we_i && !cfg_we_i) |=> (mask_q[$past(st_idx_i)] == $past(mask_q[st_idx_i])));
endmodule

// File: rtl/afl_scan_ctrl.sv
module afl_scan_ctrl
  import afl_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  parameter int IDX_W   = 5,
  parameter int PTR_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             id_valid_i,
  input  logic             frame_done_i,
  input  logic             obj_match_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             frame_latch_o,
  output logic             store_we_o,
  output logic             store_o,
  output logic             hit_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_OBJ - 1);
  localparam logic [PTR_W-1:0] PAST = PTR_W'(NUM_OBJ);

  afl_state_e       state_q, state_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pend_q, pend_d;
  logic             restart;

  always_comb begin
    state_d       = state_q;
    ptr_d         = ptr_q;
    pend_d        = pend_q;
    store_we_o    = 1'b0;
    restart       = (state_q != ST_IDLE) && upd_i && (PTR_W'(upd_idx_i) <= ptr_q);
    frame_latch_o = frame_done_i && (state_q != ST_IDLE) && !pend_q && !id_valid_i;
    if (frame_latch_o) pend_d = 1'b1;
    if (id_valid_i) begin
      state_d = ST_SCAN;
      ptr_d   = '0;
      pend_d  = 1'b0;
    end else if (restart) begin
      // objects below upd_idx_i were already rejected and are unchanged
      state_d = ST_SCAN;
      ptr_d   = PTR_W'(upd_idx_i);
    end else begin
      unique case (state_q)
        ST_SCAN: begin
          if (obj_match_i)        state_d = ST_FOUND;
          else if (ptr_q == LAST) begin
            state_d = ST_MISS;
            ptr_d   = PAST;
          end else                ptr_d = ptr_q + 1'b1;
        end
        ST_FOUND: if (pend_q) begin
          store_we_o = 1'b1;
          state_d    = ST_IDLE;
          pend_d     = 1'b0;
        end
        ST_MISS: if (pend_q) begin
          state_d = ST_IDLE;
          pend_d  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      pend_q  <= 1'b0;
      store_o <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      pend_q  <= pend_d;
      store_o <= store_we_o;
    end
  end

  assign ptr_o = ptr_q;
  assign hit_o = (state_q == ST_FOUND);

  // R5
  store_after_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_o |-> $past(hit_o));

  // R8
  miss_no_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MISS) |=> !store_o);

  // R12
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PAST);

  // R9
  restart_rescan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart && !id_valid_i) |=> (state_q == ST_SCAN && ptr_q == $past(PTR_W'(upd_idx_i))));
endmodule

// File: rtl/afl_top.sv
module afl_top #(
  parameter int NUM_OBJ   = 32,
  parameter int ID_W      = 29,
  parameter int MAX_BYTES = 8,
  localparam int DLC_W    = 4,
  localparam int DATA_W   = 8 * MAX_BYTES,
  localparam int IDX_W    = $clog2(NUM_OBJ),
  localparam int PTR_W    = $clog2(NUM_OBJ + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              id_valid_i,
  input  logic [ID_W-1:0]   rx_id_i,
  input  logic              frame_done_i,
  input  logic [DLC_W-1:0]  rx_dlc_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_tx_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic [ID_W-1:0]   cfg_mask_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [DLC_W-1:0]  rd_dlc_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              hit_o,
  output logic [IDX_W-1:0]  match_idx_o,
  output logic              store_o
);
  logic [ID_W-1:0]   rx_id_q;
  logic [DLC_W-1:0]  rx_dlc_q;
  logic [DATA_W-1:0] rx_data_q;
  logic [PTR_W-1:0]  ptr;
  logic [IDX_W-1:0]  sel_idx;
  logic              frame_latch, store_we, upd, obj_match;
  logic              sel_valid, sel_tx;
  logic [ID_W-1:0]   sel_id, sel_mask;

  assign upd     = cfg_we_i && (PTR_W'(cfg_idx_i) < PTR_W'(NUM_OBJ));
  assign sel_idx = ptr[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_id_q   <= '0;
      rx_dlc_q  <= '0;
      rx_data_q <= '0;
    end else begin
      if (id_valid_i) rx_id_q <= rx_id_i;
      if (frame_latch) begin
        rx_dlc_q  <= rx_dlc_i;
        rx_data_q <= rx_data_i;
      end
    end
  end

  afl_obj_store #(
    .NUM_OBJ(NUM_OBJ), .ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_valid_i(cfg_valid_i),
    .cfg_tx_i   (cfg_tx_i),
    .cfg_id_i   (cfg_id_i),
    .cfg_mask_i (cfg_mask_i),
    .st_we_i    (store_we),
    .st_idx_i   (sel_idx),
    .st_id_i    (rx_id_q),
    .st_dlc_i   (rx_dlc_q),
    .st_data_i  (rx_data_q),
    .sel_idx_i  (sel_idx),
    .sel_valid_o(sel_valid),
    .sel_tx_o   (sel_tx),
    .sel_id_o   (sel_id),
    .sel_mask_o (sel_mask),
    .rd_idx_i   (rd_idx_i),
    .rd_id_o    (rd_id_o),
    .rd_dlc_o   (rd_dlc_o),
    .rd_data_o  (rd_data_o)
  );

  afl_match #(.ID_W(ID_W)) i_match (
    .valid_i (sel_valid),
    .tx_i    (sel_tx),
    .obj_id_i(sel_id),
    .mask_i  (sel_mask),
    .rx_id_i (rx_id_q),
    .match_o (obj_match)
  );

  afl_scan_ctrl #(.NUM_OBJ(NUM_OBJ), .IDX_W(IDX_W), .PTR_W(PTR_W)) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .id_valid_i   (id_valid_i),
    .frame_done_i (frame_done_i),
    .obj_match_i  (obj_match),
    .upd_i        (upd),
    .upd_idx_i    (cfg_idx_i),
    .ptr_o        (ptr),
    .frame_latch_o(frame_latch),
    .store_we_o   (store_we),
    .store_o      (store_o),
    .hit_o        (hit_o)
  );

  assign match_idx_o = sel_idx;

  // R2
  hit_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> obj_match);

  // R1
  found_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (sel_valid && !sel_tx));
endmodule

// File: tb/test_afl_top.sv
`timescale 1ns/1ps
module test_afl_top;
  localparam int N  = 8;
  localparam int IW = 8;
  localparam int XW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          id_valid_i = 1'b0;
  logic [IW-1:0] rx_id_i = '0;
  logic          frame_done_i = 1'b0;
  logic [3:0]    rx_dlc_i = '0;
  logic [63:0]   rx_data_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [XW-1:0] cfg_idx_i = '0;
  logic          cfg_valid_i = 1'b0;
  logic          cfg_tx_i = 1'b0;
  logic [IW-1:0] cfg_id_i = '0;
  logic [IW-1:0] cfg_mask_i = '0;
  logic [XW-1:0] rd_idx_i = '0;
  logic [IW-1:0] rd_id_o;
  logic [3:0]    rd_dlc_o;
  logic [63:0]   rd_data_o;
  logic          hit_o;
  logic [XW-1:0] match_idx_o;
  logic          store_o;

  int checks = 0;
  int fails  = 0;

  logic          m_valid [N];
  logic          m_tx    [N];
  logic [IW-1:0] m_id    [N];
  logic [IW-1:0] m_mask  [N];
  logic [3:0]    m_dlc   [N];
  logic [63:0]   m_data  [N];

  afl_top #(.NUM_OBJ(N), .ID_W(IW), .MAX_BYTES(8)) i_afl_top (.*);

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_match(input logic [IW-1:0] rx);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && !m_tx[i] && (((rx ^ m_id[i]) & m_mask[i]) == '0)) return i;
    return -1;
  endfunction

  function automatic logic [63:0] mkdata(input int n);
    logic [63:0] d;
    for (int b = 0; b < 8; b++) d[b*8 +: 8] = 8'(n * 7 + b * 13 + 1);
    return d;
  endfunction

  task automatic cfg_obj(input int idx, input bit v, input bit tx, input logic [IW-1:0] id,
                         input logic [IW-1:0] mask);
    cfg_we_i = 1'b1; cfg_idx_i = XW'(idx); cfg_valid_i = v; cfg_tx_i = tx;
    cfg_id_i = id; cfg_mask_i = mask;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    m_valid[idx] = v; m_tx[idx] = tx; m_id[idx] = id; m_mask[idx] = mask;
  endtask

  task automatic send_id(input logic [IW-1:0] id);
    id_valid_i = 1'b1; rx_id_i = id;
    @(negedge clk_i);
    id_valid_i = 1'b0;
  endtask

  task automatic send_end(input logic [3:0] dlc, input logic [63:0] data);
    frame_done_i = 1'b1; rx_dlc_i = dlc; rx_data_i = data;
    @(negedge clk_i);
    frame_done_i = 1'b0;
  endtask

  task automatic wait_store(output bit seen, output int idx);
    seen = 1'b0; idx = -1;
    for (int c = 0; c < 8; c++) begin
      if (store_o) begin
        seen = 1'b1; idx = int'(match_idx_o);
        break;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic check_obj(input int i, input string req);
    rd_idx_i = XW'(i);
    #1;
    chk(rd_id_o == m_id[i], req, 64'(rd_id_o), 64'(m_id[i]));
    chk(rd_dlc_o == m_dlc[i], req, 64'(rd_dlc_o), 64'(m_dlc[i]));
    chk(rd_data_o == m_data[i], req, rd_data_o, m_data[i]);
    @(negedge clk_i);
  endtask

  task automatic store_model(input int e, input logic [IW-1:0] id, input logic [3:0] dlc,
                             input logic [63:0] data);
    m_id[e] = id; m_dlc[e] = dlc; m_data[e] = data;
  endtask

  // full frame; expected destination from the bench model
  task automatic run_frame(input logic [IW-1:0] id, input logic [3:0] dlc, input logic [63:0] data,
                           input string req);
    int e, idx;
    bit early, seen;
    e = exp_match(id);
    early = 1'b0;
    send_id(id);
    repeat (N + 2) begin
      if (store_o) early = 1'b1;
      @(negedge clk_i);
    end
    chk(!early, "R5 no store before frame end", 64'(early), 64'd0);
    if (e >= 0) chk(hit_o && match_idx_o == XW'(e), req, 64'(match_idx_o), 64'(e));
    else        chk(!hit_o, "R8 hit low", 64'(hit_o), 64'd0);
    send_end(dlc, data);
    wait_store(seen, idx);
    if (e >= 0) begin
      chk(seen && idx == e, req, 64'(idx), 64'(e));
      store_model(e, id, dlc, data);
      check_obj(e, "R6 stored frame");
    end else begin
      chk(!seen, "R8 no store", 64'(seen), 64'd0);
      for (int i = 0; i < N; i++) check_obj(i, "R8 objects unchanged");
    end
  endtask

  task automatic finish_pending(input int exp_idx, input logic [IW-1:0] id, input logic [3:0] dlc,
                                input logic [63:0] data, input string req);
    bit seen;
    int idx;
    send_end(dlc, data);
    wait_store(seen, idx);
    chk(seen && idx == exp_idx, req, 64'(idx), 64'(exp_idx));
    store_model(exp_idx, id, dlc, data);
    check_obj(exp_idx, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_tx[i] = 1'b0; m_id[i] = '0; m_mask[i] = '0;
      m_dlc[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(!hit_o && !store_o, "R11 reset outputs", 64'({hit_o, store_o}), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < N; i++) check_obj(i, "R11 reset objects");

    // R1 all objects inactive: nothing matches
    run_frame(8'h00, 4'd1, mkdata(1), "R1 inactive");

    // R2 R4 distinct identifiers, one target each
    for (int i = 0; i < N; i++) cfg_obj(i, 1'b1, 1'b0, IW'(8'h40 + i * 8'h11), 8'hFF);
    for (int t = 0; t < N; t++) run_frame(m_id[t], 4'(t), mkdata(t + 10), "R2 exact match");

    // R12 scan latency of K+1 edges
    for (int k = 0; k < N; k++) begin
      send_id(m_id[k]);
      repeat (k) @(negedge clk_i);
      chk(!hit_o, "R12 hit not yet", 64'(hit_o), 64'd0);
      @(negedge clk_i);
      chk(hit_o && match_idx_o == XW'(k), "R12 hit at K+1", 64'(match_idx_o), 64'(k));
      finish_pending(k, m_id[k], 4'd8, mkdata(k + 30), "R12 store");
    end

    // R1 R3 R4 lower objects inactive or transmit; lowest receive match wins
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < N; i++)
        cfg_obj(i, (i < k) ? (i % 2 == 0) : 1'b1, (i < k) ? (i % 2 == 0) : 1'b0, 8'h5A, 8'hFF);
      run_frame(8'h5A, 4'(k), mkdata(k + 50), "R3 R4 lowest receive");
    end

    // R2 R7 R8 exhaustive identifier sweep over mixed masks
    cfg_obj(0, 1'b1, 1'b0, 8'hA0, 8'hF0);
    cfg_obj(1, 1'b1, 1'b0, 8'h3C, 8'hFF);
    cfg_obj(2, 1'b1, 1'b0, 8'h05, 8'h0F);
    cfg_obj(3, 1'b1, 1'b1, 8'h00, 8'h00);
    cfg_obj(4, 1'b0, 1'b0, 8'h00, 8'h00);
    cfg_obj(5, 1'b1, 1'b0, 8'h40, 8'hC0);
    cfg_obj(6, 1'b1, 1'b0, 8'h81, 8'h81);
    cfg_obj(7, 1'b1, 1'b0, 8'h02, 8'h03);
    for (int v = 0; v < 256; v++) run_frame(IW'(v), 4'(v % 9), mkdata(v), "R2 R7 masked sweep");

    // R7 masked identifier bits taken from the frame
    cfg_obj(0, 1'b1, 1'b0, 8'h90, 8'hF0);
    run_frame(8'h9B, 4'd3, mkdata(77), "R7 masked overwrite");
    chk(m_id[0] == 8'h9B, "R7 model id", 64'(m_id[0]), 64'h9B);

    // R9 update below the found object
    for (int i = 0; i < N; i++) cfg_obj(i, 1'b1, 1'b0, IW'(8'h10 + i), 8'hFF);
    cfg_obj(5, 1'b1, 1'b0, 8'h77, 8'hFF);
    send_id(8'h77);
    repeat (N) @(negedge clk_i);
    chk(hit_o && match_idx_o == 3'd5, "R9 found before update", 64'(match_idx_o), 64'd5);
    cfg_obj(2, 1'b1, 1'b0, 8'h77, 8'hFF);
    chk(!hit_o, "R9 rescan after update", 64'(hit_o), 64'd0);
    finish_pending(2, 8'h77, 4'd4, mkdata(90), "R9 lower object takes frame");

    // R9 found object invalidated, later object takes the frame
    for (int i = 0; i < N; i++) cfg_obj(i, 1'b1, 1'b0, IW'(8'h20 + i), 8'hFF);
    cfg_obj(5, 1'b1, 1'b0, 8'h77, 8'hFF);
    cfg_obj(7, 1'b1, 1'b0, 8'h77, 8'hFF);
    send_id(8'h77);
    repeat (N) @(negedge clk_i);
    cfg_obj(5, 1'b0, 1'b0, 8'h77, 8'hFF);
    repeat (4) @(negedge clk_i);
    finish_pending(7, 8'h77, 4'd5, mkdata(91), "R9 invalidated found object");

    // R10 update above the found object
    for (int i = 0; i < N; i++) cfg_obj(i, 1'b1, 1'b0, IW'(8'h30 + i), 8'hFF);
    cfg_obj(3, 1'b1, 1'b0, 8'h66, 8'hFF);
    send_id(8'h66);
    repeat (N) @(negedge clk_i);
    cfg_obj(6, 1'b1, 1'b0, 8'h66, 8'hFF);
    chk(hit_o && match_idx_o == 3'd3, "R10 found index kept", 64'(match_idx_o), 64'd3);
    finish_pending(3, 8'h66, 4'd6, mkdata(92), "R10 store unchanged");
    check_obj(6, "R10 higher object untouched");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule